// File: doc/BRIEF.md
# Start-Stop Serial Character Transmitter

This block turns parallel characters into a start-stop framed bit stream on one output line. A character enters through a valid/ready handshake. The block sends a low start bit. It then sends 5 to 8 data bits, lowest bit first, and an optional parity bit. A high stop period ends the frame, and the line then rests high. All timing comes from an enable pulse that fires sixteen times per bit period. Because of this, the stop period is set in sixteenths of a bit rather than in whole bits.

Besides ordinary characters, the block can send two special frames, each one character time long. A break frame holds the line low. A preamble frame holds the line at the idle high level. A freeze input pauses the frame at the next bit boundary and keeps the line steady until freeze is released. The frame format is captured when each frame starts, so the configuration pins may change while a frame is on the line.

Top module: `async_char_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txOut` is high and `busy` is low. `inReady` is high in this state unless `freeze`, `breakReq` or `preambleReq` is asserted.
- R2: A character frame starts with a low start bit. The data bits follow, least significant first. The parity bit, when enabled, comes next, and the stop period comes last at the high level. The start bit, each data bit and the parity bit each last exactly 16 `tickEn` pulses. The cycle in which the frame starts counts as none of them.
- R3: `cfgDataLen` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `inData` above the selected length are never sent and do not enter the parity.
- R4: `cfgParMode` selects the parity bit. 0 means no parity bit. 1 means even parity: the data ones plus the parity bit give an even count. 2 means odd parity. 3 means the parity bit is sent at the level of `cfgParLevel`.
- R5: `cfgStopSix` sets the stop period in `tickEn` pulses. Values 9 to 31 are used as given, 0 means 32, and 1 to 8 are raised to 9. `busy` falls in the cycle after the last pulse of the stop period.
- R6: A character is accepted on a clock edge where `inValid` and `inReady` are both high. `busy` rises on that same edge. The data length, parity setting and stop length in force at that edge apply to the whole frame. A character held valid at the end of a frame starts on the very next edge.
- R7: When idle and not frozen, `breakReq` starts a break frame in preference to a preamble or a character. The line stays low for one full character time under the current configuration: start, data, parity and stop positions. It then returns high. A pending character waits with `inReady` low and is sent afterwards.
- R8: When idle and not frozen, and with no break requested, `preambleReq` starts a preamble frame ahead of any pending character. The line stays high and `busy` stays high for one full character time.
- R9: If `freeze` is high on the `tickEn` pulse that would end a bit or the stop period, the frame does not advance. The line keeps that bit's level and `busy` stays high. The frame advances on the first pulse at which `freeze` is low. While idle, `freeze` high keeps `inReady` low and no frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Enable pulse, 16 per bit period |
| inValid | input | 1 | Character offered |
| inReady | output | 1 | Character can be accepted this cycle |
| inData | input | DATA_W | Character, least significant bit sent first |
| cfgDataLen | input | 2 | Data length code (0..3 gives 5..8 bits) |
| cfgParMode | input | 2 | Parity: 0 none, 1 even, 2 odd, 3 fixed level |
| cfgParLevel | input | 1 | Parity level used in fixed mode |
| cfgStopSix | input | 5 | Stop period in sixteenths of a bit (0 means 32) |
| breakReq | input | 1 | Request one break frame |
| preambleReq | input | 1 | Request one preamble frame |
| freeze | input | 1 | Pause at the next bit boundary |
| txOut | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The bench uses the default parameters: 8 data bits at most, a minimum of 5, and 16 pulses per bit. With these values every data-length code, every parity mode and the whole stop range can be reached. That range includes the encoded zero meaning 32 and the raised low values. The bench pulses `tickEn` on every second clock, so a bit takes 32 clocks. A single freeze can then span several bit periods, and two back-to-back frames can be checked within a few hundred cycles. Each bit boundary is tracked by a tick-accurate line model that sees the same freeze input.

// File: rtl/async_char_tx_pkg.sv
package async_char_tx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_FIXED = 2'd3
  } parMode_e;

  typedef enum logic [1:0] {
    KIND_CHAR     = 2'd0,
    KIND_BREAK    = 2'd1,
    KIND_PREAMBLE = 2'd2
  } frameKind_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;        // frame begins: capture data, drive start level
    frameKind_e kind;        // kind of frame being loaded
    logic       shiftOut;    // next data bit goes onto the line
    logic       sendParity;  // parity bit goes onto the line
    logic       sendStop;    // stop level goes onto the line
    logic       goIdle;      // frame over, line returns to mark
  } dpStrobe_t;

endpackage

// File: rtl/async_char_tx_ctrl.sv
module async_char_tx_ctrl
  import async_char_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_DATA = 5,
  parameter int OVS      = 16,
  localparam int LEN_W   = $clog2(DATA_W - MIN_DATA + 1),
  localparam int STOP_W  = $clog2(2 * OVS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              freeze,
  input  logic              inValid,
  input  logic              breakReq,
  input  logic              preambleReq,
  input  logic [LEN_W-1:0]  cfgDataLen,
  input  logic [1:0]        cfgParMode,
  input  logic [STOP_W-1:0] cfgStopSix,
  output logic              inReady,
  output logic              busy,
  output dpStrobe_t         strobe
);

  localparam int BIT_W    = $clog2(DATA_W + 1);
  localparam int CNT_W    = STOP_W;
  localparam int STOP_MIN = OVS / 2 + 1;
  localparam int STOP_MAX = 2 * OVS;

  txState_e          state, stAdv;
  logic [CNT_W-1:0]  tickCnt, lastCnt, stopLast, stopLastNew;
  logic [BIT_W-1:0]  bitsLeft, nData;
  logic              parOn;
  logic              startOk, takeBreak, takePre, takeChar, atEdge, advance;

  // start arbitration: break, then preamble, then character
  assign startOk   = (state == ST_IDLE) && !freeze;
  assign takeBreak = startOk && breakReq;
  assign takePre   = startOk && !breakReq && preambleReq;
  assign inReady   = startOk && !breakReq && !preambleReq;
  assign takeChar  = inReady && inValid;
  assign busy      = (state != ST_IDLE);

  // stop length in sixteenths, minus one, with zero meaning the maximum
  always_comb begin
    if (cfgStopSix == '0)
      stopLastNew = CNT_W'(STOP_MAX - 1);
    else if (cfgStopSix < CNT_W'(STOP_MIN))
      stopLastNew = CNT_W'(STOP_MIN - 1);
    else
      stopLastNew = cfgStopSix - CNT_W'(1);
  end

  assign lastCnt = (state == ST_STOP) ? stopLast : CNT_W'(OVS - 1);
  assign atEdge  = tickEn && busy && (tickCnt == lastCnt);
  assign advance = atEdge && !freeze;

  always_comb begin
    case (state)
      ST_START:  stAdv = ST_DATA;
      ST_DATA:   stAdv = (bitsLeft == BIT_W'(1)) ? (parOn ? ST_PARITY : ST_STOP) : ST_DATA;
      ST_PARITY: stAdv = ST_STOP;
      default:   stAdv = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe            = '0;
    strobe.load       = takeBreak || takePre || takeChar;
    strobe.kind       = takeBreak ? KIND_BREAK : (takePre ? KIND_PREAMBLE : KIND_CHAR);
    strobe.shiftOut   = advance && (stAdv == ST_DATA);
    strobe.sendParity = advance && (stAdv == ST_PARITY);
    strobe.sendStop   = advance && (stAdv == ST_STOP);
    strobe.goIdle     = advance && (state == ST_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitsLeft <= '0;
      nData    <= '0;
      parOn    <= 1'b0;
      stopLast <= '0;
    end else if (strobe.load) begin
      state    <= ST_START;
      tickCnt  <= '0;
      nData    <= BIT_W'(MIN_DATA) + BIT_W'(cfgDataLen);
      parOn    <= (cfgParMode != PAR_NONE);
      stopLast <= stopLastNew;
    end else if (advance) begin
      state   <= stAdv;
      tickCnt <= '0;
      if (state == ST_START)
        bitsLeft <= nData;
      else if (state == ST_DATA)
        bitsLeft <= bitsLeft - BIT_W'(1);
    end else if (tickEn && busy && !atEdge) begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  // R9: a frozen frame makes no progress
  a_r9_freeze_holds_state: assert property (@(posedge clk) disable iff (!rstN)
    (busy && freeze) |=> (state == $past(state)));

  // R5: busy only ends on a tick during the stop period
  a_r5_end_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(state) == ST_STOP && $past(tickEn)));

  // R6: an accepted character starts a frame on the same edge
  a_r6_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> busy);

endmodule

// File: rtl/async_char_tx_dp.sv
module async_char_tx_dp
  import async_char_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_DATA = 5,
  localparam int LEN_W   = $clog2(DATA_W - MIN_DATA + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [LEN_W-1:0]  cfgDataLen,
  input  logic [1:0]        cfgParMode,
  input  logic              cfgParLevel,
  output logic              txOut
);

  localparam int BIT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] shReg, maskedData;
  logic [BIT_W-1:0]  lenNow;
  logic              parBit, parNew, dataXor;
  frameKind_e        kindR;

  assign lenNow = BIT_W'(MIN_DATA) + BIT_W'(cfgDataLen);

  // bits above the selected length do not take part in parity
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < MIN_DATA) begin : g_always
      assign maskedData[i] = inData[i];
    end else begin : g_optional
      assign maskedData[i] = inData[i] & (lenNow > BIT_W'(i));
    end
  end

  assign dataXor = ^maskedData;

  always_comb begin
    case (cfgParMode)
      PAR_EVEN:  parNew = dataXor;
      PAR_ODD:   parNew = ~dataXor;
      PAR_FIXED: parNew = cfgParLevel;
      default:   parNew = 1'b0;
    endcase
  end

  function automatic logic shapeBit(logic raw, frameKind_e k);
    case (k)
      KIND_BREAK:    return 1'b0;
      KIND_PREAMBLE: return 1'b1;
      default:       return raw;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
      kindR  <= KIND_CHAR;
      txOut  <= 1'b1;
    end else if (strobe.load) begin
      shReg  <= inData;
      parBit <= parNew;
      kindR  <= strobe.kind;
      txOut  <= shapeBit(1'b0, strobe.kind);
    end else if (strobe.shiftOut) begin
      txOut  <= shapeBit(shReg[0], kindR);
      shReg  <= shReg >> 1;
    end else if (strobe.sendParity) begin
      txOut  <= shapeBit(parBit, kindR);
    end else if (strobe.sendStop) begin
      txOut  <= shapeBit(1'b1, kindR);
    end else if (strobe.goIdle) begin
      txOut  <= 1'b1;
    end
  end

  // R2: a character frame opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == KIND_CHAR) |=> !txOut);

  // R7: a break frame pulls the line low at once
  a_r7_break_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == KIND_BREAK) |=> !txOut);

  // R8: a preamble frame keeps the line at mark
  a_r8_preamble_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == KIND_PREAMBLE) |=> txOut);

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
  import async_char_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_DATA = 5,
  parameter int OVS      = 16,
  localparam int LEN_W   = $clog2(DATA_W - MIN_DATA + 1),
  localparam int STOP_W  = $clog2(2 * OVS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic [LEN_W-1:0]  cfgDataLen,
  input  logic [1:0]        cfgParMode,
  input  logic              cfgParLevel,
  input  logic [STOP_W-1:0] cfgStopSix,
  input  logic              breakReq,
  input  logic              preambleReq,
  input  logic              freeze,
  output logic              txOut,
  output logic              busy
);

  dpStrobe_t strobe;

  async_char_tx_ctrl #(.DATA_W(DATA_W), .MIN_DATA(MIN_DATA), .OVS(OVS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .freeze      (freeze),
    .inValid     (inValid),
    .breakReq    (breakReq),
    .preambleReq (preambleReq),
    .cfgDataLen  (cfgDataLen),
    .cfgParMode  (cfgParMode),
    .cfgStopSix  (cfgStopSix),
    .inReady     (inReady),
    .busy        (busy),
    .strobe      (strobe)
  );

  async_char_tx_dp #(.DATA_W(DATA_W), .MIN_DATA(MIN_DATA)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inData      (inData),
    .cfgDataLen  (cfgDataLen),
    .cfgParMode  (cfgParMode),
    .cfgParLevel (cfgParLevel),
    .txOut       (txOut)
  );

  // R1: an idle line rests at mark
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

endmodule

// File: tb/async_char_tx_test.sv
module async_char_tx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inData = '0;
  logic [1:0] cfgDataLen = 2'd3;
  logic [1:0] cfgParMode = 2'd0;
  logic       cfgParLevel = 1'b0;
  logic [4:0] cfgStopSix = 5'd16;
  logic       breakReq = 1'b0;
  logic       preambleReq = 1'b0;
  logic       freeze = 1'b0;
  logic       txOut;
  logic       busy;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;
  int tickDiv = 0;

  async_char_tx uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .inValid(inValid), .inReady(inReady),
    .inData(inData), .cfgDataLen(cfgDataLen), .cfgParMode(cfgParMode),
    .cfgParLevel(cfgParLevel), .cfgStopSix(cfgStopSix), .breakReq(breakReq),
    .preambleReq(preambleReq), .freeze(freeze), .txOut(txOut), .busy(busy)
  );

  always #2 clk = ~clk;

  // one tick on every second clock, changed away from the active edge
  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 2;
    tickEn  = (tickDiv == 0);
  end

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishUp();
  end

  // {txOut, busy, inReady}
  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp, int p);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s at tick %0d: actual=%b expected=%b (line,busy,ready)", tag, p, act, exp);
    end
  endtask

  function automatic bit expPar(logic [7:0] d, int n, int mode, bit lvl);
    bit x = 0;
    for (int i = 0; i < n; i++) x ^= d[i];
    case (mode)
      1: return x;
      2: return ~x;
      3: return lvl;
      default: return 0;
    endcase
  endfunction

  // Follows one frame that starts on the next rising edge. kind: 0 char, 1 break, 2 preamble.
  task automatic runFrame(string tag, int kind, logic [7:0] data, int nData, bit parOn,
                          bit parBit, int stopLen, bit keepValid, logic [7:0] nextData,
                          int fzA, int fzB, bit scramble);
    int nBits = 1 + nData + (parOn ? 1 : 0);
    int tEnd  = nBits * 16 + stopLen;
    int p = 0;
    int cyc = 0;
    int idx;
    bit lvl;
    bit edgeNow;
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (cyc == 0) begin
        breakReq = 0;
        preambleReq = 0;
        if (keepValid) inData = nextData;
        else inValid = 0;
        if (scramble) begin
          cfgDataLen = ~cfgDataLen;
          cfgParMode = 2'd3;
          cfgParLevel = ~cfgParLevel;
          cfgStopSix = 5'd31;
        end
      end
      freeze = (cyc >= fzA && cyc < fzB);
      cyc++;
      idx = p / 16;
      if (kind == 1) lvl = 0;
      else if (kind == 2) lvl = 1;
      else if (idx == 0) lvl = 0;
      else if (idx <= nData) lvl = data[idx-1];
      else if (parOn && idx == nData + 1) lvl = parBit;
      else lvl = 1;
      if (p < tEnd) chk(tag, {txOut, busy, inReady}, {lvl, 1'b1, 1'b0}, p);
      else begin
        chk(tag, {txOut, busy, inReady}, 3'b101, p);
        break;
      end
      @(posedge clk);
      if (tickEn) begin
        edgeNow = (((p + 1) % 16 == 0) && (p + 1 <= nBits * 16)) || (p + 1 == tEnd);
        if (!(edgeNow && freeze)) p++;
      end
    end
  endtask

  task automatic sendChar(string tag, logic [7:0] d, int lenCode, int mode, bit lvl,
                          logic [4:0] stopCode, int stopLen);
    cfgDataLen = 2'(lenCode);
    cfgParMode = 2'(mode);
    cfgParLevel = lvl;
    cfgStopSix = stopCode;
    inData = d;
    inValid = 1;
    runFrame(tag, 0, d, 5 + lenCode, mode != 0, expPar(d, 5 + lenCode, mode, lvl),
             stopLen, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 reset idle", {txOut, busy, inReady}, 3'b101, 0);
  endtask

  task automatic testEvenParity();
    sendChar("R2 R4 even 8-bit", 8'h5A, 3, 1, 0, 5'd16, 16);
    sendChar("R2 R4 even odd-count", 8'h07, 3, 1, 0, 5'd16, 16);
  endtask

  task automatic testShortOdd();
    // upper three bits set but not sent, not in parity
    sendChar("R3 R4 5-bit odd", 8'hF3, 0, 2, 0, 5'd9, 9);
  endtask

  task automatic testStopCodes();
    sendChar("R3 R5 6-bit stop zero", 8'h2D, 1, 0, 0, 5'd0, 32);
    sendChar("R4 R5 7-bit fixed1 stop raised", 8'h41, 2, 3, 1, 5'd3, 9);
    sendChar("R4 R5 8-bit fixed0 stop 24", 8'hFF, 3, 3, 0, 5'd24, 24);
  endtask

  task automatic testCapture();
    cfgDataLen = 2'd1; cfgParMode = 2'd1; cfgParLevel = 0; cfgStopSix = 5'd12;
    inData = 8'h3B; inValid = 1;
    runFrame("R6 config captured", 0, 8'h3B, 6, 1, expPar(8'h3B, 6, 1, 0), 12, 0, 8'h00, 0, 0, 1);
  endtask

  task automatic testBackToBack();
    cfgDataLen = 2'd3; cfgParMode = 2'd0; cfgStopSix = 5'd10;
    inData = 8'hA5; inValid = 1;
    runFrame("R6 back-to-back first", 0, 8'hA5, 8, 0, 0, 10, 1, 8'h3C, 0, 0, 0);
    runFrame("R6 back-to-back second", 0, 8'h3C, 8, 0, 0, 10, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic testBreakPending();
    cfgDataLen = 2'd2; cfgParMode = 2'd2; cfgStopSix = 5'd20;
    inData = 8'h66; inValid = 1; breakReq = 1; preambleReq = 1;
    runFrame("R7 break wins, char waits", 1, 8'h00, 7, 1, 0, 20, 1, 8'h66, 0, 0, 0);
    runFrame("R7 char after break", 0, 8'h66, 7, 1, expPar(8'h66, 7, 2, 0), 20, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic testPreamble();
    cfgDataLen = 2'd0; cfgParMode = 2'd0; cfgStopSix = 5'd16;
    inData = 8'h11; inValid = 1; preambleReq = 1;
    runFrame("R8 preamble first", 2, 8'h00, 5, 0, 0, 16, 1, 8'h11, 0, 0, 0);
    runFrame("R8 char after preamble", 0, 8'h11, 5, 0, 0, 16, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic testFreezeMid();
    cfgDataLen = 2'd3; cfgParMode = 2'd1; cfgStopSix = 5'd16;
    inData = 8'h96; inValid = 1;
    // frozen from cycle 40 to 240: spans the end of data bit 0 (about cycle 64)
    runFrame("R9 freeze mid-frame", 0, 8'h96, 8, 1, expPar(8'h96, 8, 1, 0), 16, 0, 8'h00, 40, 240, 0);
    cfgStopSix = 5'd9;
    inData = 8'h01; inValid = 1;
    // frozen across the end of the stop period
    runFrame("R9 freeze at stop end", 0, 8'h01, 8, 1, expPar(8'h01, 8, 1, 0), 9, 0, 8'h00, 280, 400, 0);
  endtask

  task automatic testFreezeIdle();
    cfgDataLen = 2'd3; cfgParMode = 2'd0; cfgStopSix = 5'd16;
    freeze = 1; inData = 8'hC3; inValid = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R9 freeze blocks start", {txOut, busy, inReady}, 3'b100, i);
    end
    freeze = 0;
    runFrame("R9 start after unfreeze", 0, 8'hC3, 8, 0, 0, 16, 0, 8'h00, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testEvenParity();
    testShortOdd();
    testStopCodes();
    testCapture();
    testBackToBack();
    testBreakPending();
    testPreamble();
    testFreezeMid();
    testFreezeIdle();
    repeat (4) @(negedge clk);
    chk("R1 idle at end", {txOut, busy, inReady}, 3'b101, 0);
    finishUp();
  end

endmodule